// File: doc/BRIEF.md
# Banked Operand Fetch with Slot Reuse Cache

This block gathers the three source operands of an instruction for an issue stage. The register file is split into four banks, and each bank can deliver one read per cycle. An instruction names three source registers and gives one reuse flag for each slot. When an instruction is issued, each slot keeps the value it just delivered in a small cache if its flag is set, and drops that entry if the flag is clear. If the next instruction names the same register in the same slot, that slot takes its value from the cache and makes no bank read. This can remove a bank collision that would otherwise cost a cycle.

Reads that miss the cache are arbitrated per bank. Distinct registers that fall in the same bank are read over successive cycles. A result write port updates both the banks and any cached or already gathered copy of a register, so the operands shown always match the register file. Instructions enter through a valid/ready handshake, and operands leave through a valid/ready handshake.

Top module: `operand_gather`

## Requirements
- R1: A register's bank is its index modulo 4. A bank delivers at most one register per cycle, and among pending slots in the same bank the lowest slot index is read first. With no writes, the number of gather cycles equals the largest count of distinct non-hit registers in any one bank. out_valid rises in the cycle after the last read.
- R2: The same register named in several slots in one cycle takes a single bank read, which serves all of those slots.
- R3: A slot hits when the previously issued instruction set that slot's reuse flag and named the same register in that slot. A hit slot makes no bank read. If all three slots hit, out_valid rises in the cycle after acceptance. Hits can remove a bank collision.
- R4: A cached register matches only in the slot it was stored from. The same register in another slot is a miss.
- R5: When an instruction issues with a slot's reuse flag clear, that slot's cache entry becomes invalid.
- R6: While out_valid is high, out_op0, out_op1 and out_op2 equal the current register file contents of the three named registers. This includes writes made while the instruction waited, writes to cached registers, and writes during hold.
- R7: A write to a bank blocks every read of that bank in the same cycle. The write takes priority.
- R8: in_ready is high exactly when no instruction is held. An instruction is accepted on in_valid and in_ready. out_valid stays high until out_ready, and the instruction issues on out_valid and out_ready. in_ready and out_valid are never high together.
- R9: After reset, in_ready is 1, out_valid is 0 and every cache entry is invalid. Register contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can accept an instruction |
| in_src0 | input | IW | Register index, slot 0 |
| in_src1 | input | IW | Register index, slot 1 |
| in_src2 | input | IW | Register index, slot 2 |
| in_reuse | input | 3 | Per-slot keep flag, bit s for slot s |
| wr_en | input | 1 | Result write enable |
| wr_idx | input | IW | Result register index |
| wr_data | input | DW | Result value |
| out_valid | output | 1 | All three operands present |
| out_ready | input | 1 | Issue stage takes the operands |
| out_op0 | output | DW | Operand for slot 0 |
| out_op1 | output | DW | Operand for slot 1 |
| out_op2 | output | DW | Operand for slot 2 |

## Verification
The following rules are checked on every cycle:
- at most one read per bank;
- no read of a bank that is being written;
- progress on every write-free cycle while slots are pending;
- ready and valid never high together;
- out_valid held while it waits for out_ready;
- a fully hitting instruction is ready one cycle after acceptance.

Other behaviour can only be shown by the bench scenarios, which compare timing and data each cycle against a behavioural model. These cover the exact gather cycle counts for collision patterns, hits only within the same slot, invalidation by a clear flag, the data coherence of writes to cached or held registers, and the emptied cache after reset.

// File: rtl/operand_gather.sv
`timescale 1ns/1ps
module operand_gather #(
  parameter int NREG = 64,
  parameter int DW   = 64,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_src0,
  input  logic [IW-1:0] in_src1,
  input  logic [IW-1:0] in_src2,
  input  logic [2:0]    in_reuse,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_op0,
  output logic [DW-1:0] out_op1,
  output logic [DW-1:0] out_op2
);
  localparam int ROWS = NREG / 4;
  localparam int RW   = IW - 2;

  logic          busy;
  logic [2:0]    need, reuse_q, cv, hit, pend, win, served;
  logic [IW-1:0] idx_q [3];
  logic [IW-1:0] in_idx [3];
  logic [IW-1:0] ctag [3];
  logic [DW-1:0] opd [3];
  logic [DW-1:0] cdat [3];
  logic [5:0]    bank_v;
  logic [RW-1:0] rd_row [4];
  logic [DW-1:0] rd_dat [4];
  logic          acc, iss;

  assign in_idx[0] = in_src0;
  assign in_idx[1] = in_src1;
  assign in_idx[2] = in_src2;
  assign bank_v    = {idx_q[2][1:0], idx_q[1][1:0], idx_q[0][1:0]};
  assign in_ready  = !busy;
  assign out_valid = busy && (need == 3'b000);
  assign acc       = in_valid && in_ready;
  assign iss       = out_valid && out_ready;
  assign out_op0   = opd[0];
  assign out_op1   = opd[1];
  assign out_op2   = opd[2];

  always_comb begin
    for (int s = 0; s < 3; s++)
      hit[s] = cv[s] && (ctag[s] == in_idx[s]);
  end

  always_comb begin
    for (int s = 0; s < 3; s++)
      pend[s] = busy && need[s] && !(wr_en && (wr_idx[1:0] == bank_v[2*s +: 2]));
    for (int s = 0; s < 3; s++) begin
      win[s] = pend[s];
      for (int t = 0; t < s; t++)
        if (pend[t] && (bank_v[2*t +: 2] == bank_v[2*s +: 2])) win[s] = 1'b0;
    end
    for (int s = 0; s < 3; s++) begin
      served[s] = 1'b0;
      for (int t = 0; t <= s; t++)
        if (win[t] && pend[s] && (idx_q[t] == idx_q[s])) served[s] = 1'b1;
    end
  end

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      rd_row[b] = '0;
      for (int s = 2; s >= 0; s--)
        if (win[s] && (bank_v[2*s +: 2] == 2'(b))) rd_row[b] = idx_q[s][IW-1:2];
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_bank
    logic [DW-1:0] mem [ROWS];
    always_ff @(posedge clk)
      if (wr_en && (wr_idx[1:0] == 2'(b))) mem[wr_idx[IW-1:2]] <= wr_data;
    assign rd_dat[b] = mem[rd_row[b]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      need <= 3'b000;
      cv   <= 3'b000;
    end else begin
      if (acc)      busy <= 1'b1;
      else if (iss) busy <= 1'b0;
      for (int s = 0; s < 3; s++) begin
        if (acc)              need[s] <= !hit[s];
        else if (served[s])   need[s] <= 1'b0;
        if (iss)              cv[s]   <= reuse_q[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 3; s++) begin
      if (acc) begin
        idx_q[s]   <= in_idx[s];
        reuse_q[s] <= in_reuse[s];
        opd[s]     <= (wr_en && wr_idx == in_idx[s]) ? wr_data : cdat[s];
      end else if (wr_en && wr_idx == idx_q[s]) begin
        opd[s] <= wr_data;
      end else if (served[s]) begin
        opd[s] <= rd_dat[idx_q[s][1:0]];
      end
      if (iss) begin
        ctag[s] <= idx_q[s];
        cdat[s] <= (wr_en && wr_idx == idx_q[s]) ? wr_data : opd[s];
      end else if (wr_en && wr_idx == ctag[s]) begin
        cdat[s] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/operand_gather_chk.sv
`timescale 1ns/1ps
module operand_gather_chk #(
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [2:0]    hit,
  input logic [2:0]    need,
  input logic [2:0]    win,
  input logic [2:0]    served,
  input logic [5:0]    bank_v
);
  for (genvar b = 0; b < 4; b++) begin : g_bk
    assert_one_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win[2] && bank_v[5:4] == 2'(b),
                win[1] && bank_v[3:2] == 2'(b),
                win[0] && bank_v[1:0] == 2'(b)}));
  end

  assert_progress_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (need != 3'b000) && !in_ready && !wr_en |=>
      $countones(need) < $countones($past(need)));

  assert_all_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && hit == 3'b111 |=> out_valid);

  assert_write_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !((served[0] && bank_v[1:0] == wr_idx[1:0]) ||
                (served[1] && bank_v[3:2] == wr_idx[1:0]) ||
                (served[2] && bank_v[5:4] == wr_idx[1:0])));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

bind operand_gather operand_gather_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .wr_en(wr_en), .wr_idx(wr_idx),
  .hit(hit), .need(need), .win(win), .served(served), .bank_v(bank_v)
);

// File: tb/operand_gather_test.sv
`timescale 1ns/1ps
module operand_gather_test;
  localparam int NREG = 64;
  localparam int IW   = 6;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, wr_en = 0;
  logic [IW-1:0] s0 = 0, s1 = 0, s2 = 0, wr_idx = 0;
  logic [2:0] reuse = 0;
  logic [63:0] wr_data = 0;
  logic in_ready, out_valid;
  logic [63:0] op0, op1, op2;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  operand_gather uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src0(s0), .in_src1(s1), .in_src2(s2), .in_reuse(reuse),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_op0(op0), .out_op1(op1), .out_op2(op2));

  logic [63:0] rf [NREG];
  bit m_busy;
  logic [2:0] m_need, m_reuse;
  bit m_cv [3];
  int m_idx [3];
  int m_tag [3];
  bit m_iss;
  bit taken [4];
  int wreg [4];
  int reads = 0, stalls = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_need = 0;
      for (int s = 0; s < 3; s++) m_cv[s] = 0;
    end else begin
      m_iss = m_busy && m_need == 0 && out_ready;
      if (m_busy && m_need != 0) begin
        stalls++;
        for (int b = 0; b < 4; b++) taken[b] = 0;
        for (int s = 0; s < 3; s++) begin
          if (m_need[s] && !(wr_en && (int'(wr_idx) % 4) == m_idx[s] % 4)) begin
            if (!taken[m_idx[s] % 4]) begin
              taken[m_idx[s] % 4] = 1; wreg[m_idx[s] % 4] = m_idx[s];
              m_need[s] = 0; reads++;
            end else if (wreg[m_idx[s] % 4] == m_idx[s]) m_need[s] = 0;
          end
        end
      end
      if (m_iss) begin
        for (int s = 0; s < 3; s++) begin m_cv[s] = m_reuse[s]; m_tag[s] = m_idx[s]; end
        m_busy = 0;
      end else if (!m_busy && in_valid) begin
        m_idx[0] = int'(s0); m_idx[1] = int'(s1); m_idx[2] = int'(s2);
        m_reuse = reuse;
        for (int s = 0; s < 3; s++) m_need[s] = !(m_cv[s] && m_tag[s] == m_idx[s]);
        m_busy = 1;
      end
      if (wr_en) rf[wr_idx] = wr_data;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      chk(in_ready == !m_busy, "R8", "in_ready", 64'(in_ready), 64'(!m_busy));
      chk(out_valid == (m_busy && m_need == 0), "R1", "out_valid",
          64'(out_valid), 64'(m_busy && m_need == 0));
      if (out_valid && m_busy && m_need == 0) begin
        chk(op0 == rf[m_idx[0]], "R6", "op0", op0, rf[m_idx[0]]);
        chk(op1 == rf[m_idx[1]], "R6", "op1", op1, rf[m_idx[1]]);
        chk(op2 == rf[m_idx[2]], "R6", "op2", op2, rf[m_idx[2]]);
      end
    end
  end

  task automatic wr(input int i, input logic [63:0] d);
    @(negedge clk); wr_en = 1; wr_idx = IW'(i); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run(input int a, input int b, input int c, input logic [2:0] ru,
                     input int blk, input int expn, input int hold, input string tag);
    int n;
    logic [63:0] d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; s0 = IW'(a); s1 = IW'(b); s2 = IW'(c); reuse = ru; out_ready = 0;
    @(posedge clk); #5; in_valid = 0;
    n = 0;
    while (!out_valid && n < 20) begin
      n++;
      @(negedge clk);
      wr_en = (n <= blk); wr_idx = 6'd60; wr_data = {$urandom, $urandom};
      @(posedge clk); #5;
    end
    @(negedge clk); wr_en = 0;
    chk(n == expn, tag, "gather cycles", 64'(n), 64'(expn));
    for (int h = 0; h < hold; h++) begin
      d = {$urandom, $urandom};
      wr_en = 1; wr_idx = IW'(b); wr_data = d;
      @(posedge clk); #5;
      chk(out_valid && op1 == d, "R6 R8", "held operand after write", op1, d);
      @(negedge clk); wr_en = 0;
    end
    out_ready = 1;
    @(posedge clk); #5; out_ready = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #5;
    chk(in_ready == 1 && out_valid == 0, "R9", "reset outputs",
        64'({in_ready, out_valid}), 64'b10);
    for (int i = 0; i < NREG; i++) wr(i, {$urandom, $urandom});

    run(0, 4, 8, 3'b000, 0, 3, 0, "R9 R1 empty cache, one bank");
    run(1, 2, 3, 3'b000, 0, 1, 0, "R1 distinct banks");
    run(0, 0, 4, 3'b000, 0, 2, 0, "R2 shared register read");
    run(0, 4, 8, 3'b111, 0, 3, 0, "R5 clear flag dropped slot0");
    run(0, 4, 8, 3'b000, 0, 0, 0, "R3 all slots hit");
    run(0, 4, 8, 3'b111, 0, 3, 0, "R5 entries invalidated");
    run(4, 8, 0, 3'b000, 0, 3, 0, "R4 other slot no hit");
    run(0, 4, 8, 3'b011, 0, 3, 0, "R5 rotated entries dropped");
    run(0, 4, 12, 3'b000, 0, 1, 0, "R3 hits remove collision");
    run(1, 2, 3, 3'b111, 0, 1, 0, "R1 load cache");
    wr(2, 64'h0123_4567_89ab_cdef);
    run(1, 2, 3, 3'b000, 0, 0, 0, "R6 cached register rewritten");
    chk(rf[2] == 64'h0123_4567_89ab_cdef, "R6", "model write", rf[2], 64'h0123_4567_89ab_cdef);
    run(0, 4, 8, 3'b000, 1, 4, 0, "R7 write blocks bank");
    run(1, 6, 11, 3'b000, 0, 1, 2, "R6 R8 hold with write");
    run(0, 4, 8, 3'b111, 0, 3, 0, "R1 load before reset");

    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #5;
    chk(in_ready == 1 && out_valid == 0, "R9", "outputs after reset",
        64'({in_ready, out_valid}), 64'b10);
    run(0, 4, 8, 3'b000, 0, 3, 0, "R9 cache emptied by reset");

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      in_valid  = ($urandom % 10) < 7;
      s0 = IW'($urandom % 16); s1 = IW'($urandom % 16); s2 = IW'($urandom % 16);
      reuse     = 3'($urandom);
      out_ready = ($urandom % 10) < 6;
      wr_en     = ($urandom % 10) < 3;
      wr_idx    = IW'($urandom % 16);
      wr_data   = {$urandom, $urandom};
    end
    @(negedge clk); in_valid = 0; wr_en = 0; out_ready = 1;
    repeat (8) @(negedge clk);

    $display("bank reads=%0d gather cycles=%0d", reads, stalls);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule